// File: doc/BRIEF.md
# Quadrature DLL delay controller

This block is the digital half of a delay-locked loop. It produces an internal reference clock at one quarter of the fast sample clock. It also takes back a feedback clock that has passed through an external, variable delay line. Each rising edge of the feedback clock is placed into one of four quarter-period quadrants of the reference clock. Over an interval of reference periods the block takes a majority vote on whether delay should be added or removed. It then moves a signed tap code one step toward the point where the feedback edge sits a quarter period after the reference edge. That is the 90° quadrature point.

The delay line itself is not part of the block; the tap code is its only control. A restart input holds the code at its nominal position and freezes the loop. An invert input swaps the zones that add delay with the zones that remove it, so the loop settles at three quarters of a period instead. The tap range is lopsided: it can add much more delay than it can remove. When the fixed-length line cannot reach quadrature, the code stops at a range end and raises a flag rather than wrapping. A lock flag is raised once the code has dithered back and forth around the lock point for several intervals in a row.

There is no data stream through this block, so it has no valid/ready handshake; every pin is a plain level-sensitive control or status signal.

Top module: `qdll_ctrl`

## Requirements
- R1: While `restart` is high, and in the cycle after it was high, `tap` is 0 and `locked` is 0. An active-low `rst_n` gives the same state, with both limit flags low.
- R2: `ref_clk_o` is the sample clock divided by four. It is high for two sample cycles and low for two, and is free-running regardless of `restart`.
- R3: With `invert` low, the loop settles with the delayed feedback rising edge alternating across the T/4 boundary. The period of `ref_clk_o` is T, and quadrant k (k = 0..3) is the interval from k·T/4 to (k+1)·T/4 after a rising edge of `ref_clk_o`. Edges in quadrants 3 and 0 vote to add delay (+1); edges in quadrants 1 and 2 vote to remove it (−1).
- R4: With `invert` high the two vote zones are swapped: quadrants 1 and 2 add delay and quadrants 3 and 0 remove it. The loop then settles across the 3T/4 boundary.
- R5: `tap` changes by at most one step per update interval. An interval is 16 reference periods (64 sample cycles). The step follows the majority of the votes in the interval, and a tie holds the code.
- R6: `tap` is a 7-bit two's-complement code whose upper end is +47. An add-delay decision at +47 leaves the code unchanged, and `at_max` is high exactly while the code is +47.
- R7: The lower end of `tap` is −16. A remove-delay decision at −16 leaves the code unchanged, and `at_min` is high exactly while the code is −16.
- R8: `locked` rises after 8 consecutive update intervals whose step directions alternate. It then stays high until `restart` or a change of `invert`. It is never raised while the code is held at a range end.
- R9: A change of `invert` clears `locked` on the following cycle and restarts the vote interval, without moving `tap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Hold tap at 0 and freeze the loop while high |
| invert | input | 1 | Swap add/remove-delay quadrant zones |
| fb_clk | input | 1 | Feedback clock returned from the delay line, asynchronous |
| ref_clk_o | output | 1 | Internal reference clock, clk divided by four |
| tap | output | 7 | Signed delay-tap code, −16 to +47, 0 at restart |
| locked | output | 1 | Loop dithering around the lock point |
| at_min | output | 1 | Tap code held at −16 |
| at_max | output | 1 | Tap code held at +47 |

## Verification
The bench drives a behavioural delay line with a random base offset, which makes the loop either settle on a two-code dither or run into a range end. A design that wraps instead of saturating would jump to the opposite end and never hold the flag. A design that swaps the wrong quadrants under `invert` would drift to a limit where a lock is expected, or settle a half period away. The bench also watches the spacing and size of every tap change, so a loop that steps on each feedback edge, or by more than one code, is caught. Toggling `invert` after lock checks that lock drops at once and that the loop then heads for the limit the inverted zones predict.

// File: rtl/qdll_pkg.sv
package qdll_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Quadrants 0 and 3 sit before the T/4 point and ask for more delay;
  // the invert control flips the sense of every zone.
  function automatic logic zone_adds(input logic [1:0] quad, input logic inv);
    return (quad[1] ~^ quad[0]) ^ inv;
  endfunction

endpackage

// File: rtl/qdll_phase_det.sv
module qdll_phase_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_clk,
  input  logic invert,
  output logic ref_clk_o,
  output logic edge_vld,
  output logic edge_up
);
  import qdll_pkg::*;

  logic [1:0]        phase_q;
  logic [SYNC_N-1:0] sync_q;
  logic              fb_last_q;
  logic [1:0]        quad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 2'd1;
  end

  assign ref_clk_o = ~phase_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= fb_clk;
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_last_q <= 1'b0;
    else        fb_last_q <= sync_q[SYNC_N-1];
  end

  // The rise shows up SYNC_N cycles after the quadrant in which it landed.
  assign quad     = phase_q - 2'(SYNC_N);
  assign edge_vld = sync_q[SYNC_N-1] & ~fb_last_q;
  assign edge_up  = zone_adds(quad, invert);

endmodule

// File: rtl/qdll_vote.sv
module qdll_vote #(
  parameter int VOTE_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             edge_vld,
  input  logic             edge_up,
  output logic             step_vld,
  output qdll_pkg::step_e  step_dir
);
  import qdll_pkg::*;

  localparam int SPAN = VOTE_N * 4;
  localparam int IW   = $clog2(SPAN);
  localparam int VCW  = $clog2(VOTE_N + 2);
  localparam logic [IW-1:0]  LAST = IW'(SPAN - 1);
  localparam logic [VCW-1:0] VSAT = '1;

  logic [IW-1:0]  icnt_q;
  logic [VCW-1:0] ups_q, dns_q;
  logic           vote_up, vote_dn;

  assign vote_up = edge_vld & edge_up;
  assign vote_dn = edge_vld & ~edge_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q   <= '0;
      ups_q    <= '0;
      dns_q    <= '0;
      step_vld <= 1'b0;
      step_dir <= STEP_HOLD;
    end else if (clr) begin
      icnt_q   <= '0;
      ups_q    <= '0;
      dns_q    <= '0;
      step_vld <= 1'b0;
      step_dir <= STEP_HOLD;
    end else if (icnt_q == LAST) begin
      icnt_q   <= '0;
      step_vld <= 1'b1;
      if (ups_q > dns_q)      step_dir <= STEP_UP;
      else if (dns_q > ups_q) step_dir <= STEP_DN;
      else                    step_dir <= STEP_HOLD;
      ups_q <= {{(VCW-1){1'b0}}, vote_up};
      dns_q <= {{(VCW-1){1'b0}}, vote_dn};
    end else begin
      icnt_q   <= icnt_q + IW'(1);
      step_vld <= 1'b0;
      if (vote_up && ups_q != VSAT) ups_q <= ups_q + VCW'(1);
      if (vote_dn && dns_q != VSAT) dns_q <= dns_q + VCW'(1);
    end
  end

endmodule

// File: rtl/qdll_tap_lock.sv
module qdll_tap_lock #(
  parameter int TAP_W   = 7,
  parameter int TAP_MIN = -16,
  parameter int TAP_MAX = 47,
  parameter int LOCK_N  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    inv_chg,
  input  logic                    step_vld,
  input  qdll_pkg::step_e         step_dir,
  output logic signed [TAP_W-1:0] tap,
  output logic                    locked,
  output logic                    at_min,
  output logic                    at_max
);
  import qdll_pkg::*;

  localparam int LW = $clog2(LOCK_N + 1);
  localparam logic signed [TAP_W-1:0] TMIN = TAP_W'(TAP_MIN);
  localparam logic signed [TAP_W-1:0] TMAX = TAP_W'(TAP_MAX);
  localparam logic [LW-1:0] ALT_LAST = LW'(LOCK_N - 1);
  localparam logic [LW-1:0] ALT_SAT  = LW'(LOCK_N);

  logic [LW-1:0] alt_q;
  step_e         prev_q;
  logic          prev_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap        <= '0;
      locked     <= 1'b0;
      alt_q      <= '0;
      prev_q     <= STEP_HOLD;
      prev_vld_q <= 1'b0;
    end else if (restart) begin
      tap        <= '0;
      locked     <= 1'b0;
      alt_q      <= '0;
      prev_q     <= STEP_HOLD;
      prev_vld_q <= 1'b0;
    end else if (inv_chg) begin
      locked     <= 1'b0;
      alt_q      <= '0;
      prev_vld_q <= 1'b0;
    end else if (step_vld) begin
      case (step_dir)
        STEP_UP: if (tap != TMAX) tap <= tap + TAP_W'(1);
        STEP_DN: if (tap != TMIN) tap <= tap - TAP_W'(1);
        default: ;
      endcase
      if (step_dir == STEP_HOLD) begin
        alt_q <= '0;
      end else if (prev_vld_q && step_dir != prev_q) begin
        if (alt_q == ALT_LAST) locked <= 1'b1;
        if (alt_q != ALT_SAT)  alt_q  <= alt_q + LW'(1);
      end else begin
        alt_q <= '0;
      end
      prev_q     <= step_dir;
      prev_vld_q <= (step_dir != STEP_HOLD);
    end
  end

  assign at_min = (tap == TMIN);
  assign at_max = (tap == TMAX);

endmodule

// File: rtl/qdll_ctrl.sv
module qdll_ctrl #(
  parameter int TAP_W   = 7,
  parameter int TAP_MIN = -16,
  parameter int TAP_MAX = 47,
  parameter int VOTE_N  = 16,
  parameter int LOCK_N  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    invert,
  input  logic                    fb_clk,
  output logic                    ref_clk_o,
  output logic signed [TAP_W-1:0] tap,
  output logic                    locked,
  output logic                    at_min,
  output logic                    at_max
);
  import qdll_pkg::*;

  logic  inv_d_q;
  logic  inv_chg;
  logic  edge_vld, edge_up;
  logic  step_vld;
  step_e step_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_d_q <= 1'b0;
    else        inv_d_q <= invert;
  end

  assign inv_chg = invert ^ inv_d_q;

  qdll_phase_det #(.SYNC_N(SYNC_N)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_clk   (fb_clk),
    .invert   (invert),
    .ref_clk_o(ref_clk_o),
    .edge_vld (edge_vld),
    .edge_up  (edge_up)
  );

  qdll_vote #(.VOTE_N(VOTE_N)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart | inv_chg),
    .edge_vld(edge_vld),
    .edge_up (edge_up),
    .step_vld(step_vld),
    .step_dir(step_dir)
  );

  qdll_tap_lock #(
    .TAP_W  (TAP_W),
    .TAP_MIN(TAP_MIN),
    .TAP_MAX(TAP_MAX),
    .LOCK_N (LOCK_N)
  ) u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .inv_chg (inv_chg),
    .step_vld(step_vld),
    .step_dir(step_dir),
    .tap     (tap),
    .locked  (locked),
    .at_min  (at_min),
    .at_max  (at_max)
  );

endmodule

// File: rtl/qdll_ctrl_chk.sv
module qdll_ctrl_chk #(
  parameter int TAP_W   = 7,
  parameter int TAP_MIN = -16,
  parameter int TAP_MAX = 47
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    restart,
  input logic                    invert,
  input logic                    ref_clk_o,
  input logic signed [TAP_W-1:0] tap,
  input logic                    locked
);
  localparam logic signed [TAP_W-1:0] TMIN = TAP_W'(TAP_MIN);
  localparam logic signed [TAP_W-1:0] TMAX = TAP_W'(TAP_MAX);

  a_r1_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tap == '0 && !locked));

  a_r2_ref_duty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk_o) |=> ref_clk_o ##1 !ref_clk_o);

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (tap == $past(tap) || tap == $past(tap) + TAP_W'(1)
                  || tap == $past(tap) - TAP_W'(1)));

  // Covers R6 and R7: the code never leaves its window.
  a_r6_tap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (tap >= TMIN && tap <= TMAX));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart && $stable(invert)) |=> locked);

  a_r9_invert_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(invert) |=> !locked);

endmodule

bind qdll_ctrl qdll_ctrl_chk #(
  .TAP_W  (TAP_W),
  .TAP_MIN(TAP_MIN),
  .TAP_MAX(TAP_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .restart  (restart),
  .invert   (invert),
  .ref_clk_o(ref_clk_o),
  .tap      (tap),
  .locked   (locked)
);

// File: tb/test_qdll_ctrl.sv
`timescale 1ps/1ps
module test_qdll_ctrl;

  localparam int HALF   = 2000;
  localparam int TREF   = 16000;
  localparam int STEP   = 100;
  localparam int T_MIN  = -16;
  localparam int T_MAX  = 47;
  localparam int SETTLE = 7000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              restart = 1'b0;
  logic              invert = 1'b0;
  logic              fb_clk = 1'b0;
  logic              ref_clk_o;
  logic signed [6:0] tap;
  logic              locked, at_min, at_max;

  int nchk = 0;
  int nfail = 0;
  int dly_base = 5050;
  bit done = 1'b0;

  bit mon_en = 1'b0;
  int mon_gap = 0;
  int mon_last = 0;
  int mon_viol = 0;

  always #HALF clk = ~clk;

  qdll_ctrl i_qdll_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .invert(invert),
    .fb_clk(fb_clk), .ref_clk_o(ref_clk_o), .tap(tap), .locked(locked),
    .at_min(at_min), .at_max(at_max)
  );

  // Behavioural delay line driven by the tap code.
  always @(ref_clk_o) begin
    automatic logic lv = ref_clk_o;
    automatic int   dv = dly_base + int'(tap) * STEP;
    fork
      begin
        #(dv);
        fb_clk = lv;
      end
    join_none
  end

  // R5 watcher: spacing and size of every tap move.
  always @(negedge clk) begin
    if (mon_en) begin
      if (int'(tap) != mon_last) begin
        if (mon_gap < 63 || (int'(tap) - mon_last) > 1 || (mon_last - int'(tap)) > 1)
          mon_viol++;
        mon_gap  = 0;
        mon_last = int'(tap);
      end else begin
        mon_gap++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  function automatic bit adds(input int t, input int base, input bit inv);
    automatic int d = base + t * STEP;
    automatic int q = (d % TREF) / (TREF / 4);
    return ((q == 0) || (q == 3)) ^ inv;
  endfunction

  function automatic int next_tap(input int t, input int base, input bit inv);
    if (adds(t, base, inv)) return (t < T_MAX) ? t + 1 : t;
    return (t > T_MIN) ? t - 1 : t;
  endfunction

  task automatic predict(input int start, input int base, input bit inv,
                         output int ta, output int tb);
    automatic int t = start;
    for (int i = 0; i < 300; i++) t = next_tap(t, base, inv);
    ta = t;
    tb = next_tap(t, base, inv);
  endtask

  task automatic settle_check(input int start, input int base, input bit inv);
    int ta, tb;
    bit osc;
    string rq;
    predict(start, base, inv, ta, tb);
    osc = (ta != tb);
    mon_last = int'(tap);
    mon_gap  = 0;
    mon_viol = 0;
    mon_en   = 1'b1;
    repeat (SETTLE) @(negedge clk);
    mon_en = 1'b0;
    if (osc) rq = inv ? "R4 settle 3T/4" : "R3 settle T/4";
    else     rq = (ta == T_MAX) ? "R6 saturate max" : "R7 saturate min";
    chk(int'(tap) == ta || int'(tap) == tb, rq, int'(tap), ta);
    chk(locked == osc, "R8 lock state", int'(locked), int'(osc));
    chk(at_max == (!osc && ta == T_MAX), "R6 at_max flag", int'(at_max), int'(!osc && ta == T_MAX));
    chk(at_min == (!osc && ta == T_MIN), "R7 at_min flag", int'(at_min), int'(!osc && ta == T_MIN));
    chk(mon_viol == 0, "R5 step spacing and size", mon_viol, 0);
  endtask

  task automatic run_scn(input int base, input bit inv);
    @(negedge clk);
    dly_base = base;
    invert   = inv;
    restart  = 1'b1;
    @(negedge clk);
    chk(tap == 7'sd0 && !locked, "R1 restart home", int'(tap), 0);
    repeat (3) @(negedge clk);
    chk(tap == 7'sd0 && !at_min && !at_max, "R1 restart hold", int'(tap), 0);
    restart = 1'b0;
    settle_check(0, base, inv);
  endtask

  initial begin
    automatic int highs = 0;
    automatic int rises = 0;
    automatic logic prev;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tap == 7'sd0, "R1 reset tap", int'(tap), 0);
    chk(!locked, "R1 reset lock", int'(locked), 0);
    chk(!at_min && !at_max, "R1 reset flags", int'({at_min, at_max}), 0);

    prev = ref_clk_o;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ref_clk_o) highs++;
      if (ref_clk_o && !prev) rises++;
      prev = ref_clk_o;
    end
    chk(highs == 8, "R2 reference duty", highs, 8);
    chk(rises == 4, "R2 reference period", rises, 4);

    run_scn(3550, 1'b0);   // dither at T/4
    // R9: flipping invert while locked drops lock but keeps the code.
    begin
      automatic int held = int'(tap);
      @(negedge clk);
      invert = 1'b1;
      @(negedge clk);
      chk(!locked, "R9 invert clears lock", int'(locked), 0);
      chk(int'(tap) == held, "R9 invert keeps tap", int'(tap), held);
      settle_check(held, 3550, 1'b1);
    end

    run_scn(12050, 1'b0);  // runs to +47
    run_scn(8050, 1'b0);   // runs to -16
    run_scn(11550, 1'b1);  // dither at 3T/4
    run_scn(11550, 1'b0);  // same line, zones not swapped: runs to -16

    for (int n = 0; n < 6; n++) begin
      automatic int k = 17 + int'($urandom_range(0, 183));
      automatic bit iv = bit'($urandom_range(0, 1));
      run_scn(50 + k * STEP, iv);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule